// File: doc/BRIEF.md
# Segment Privilege Check Unit

This block decides, one request at a time, whether a selector may be loaded into a segment register or whether an I/O instruction may run at the current privilege level. Four rings are numbered 0 to 3. Ring 0 has the most privilege, and a smaller number always means more privilege. The caller supplies these inputs:

- the operation kind;
- the current privilege level, taken from the low two bits of the code selector;
- the 16-bit selector, whose bits 1:0 are the requested privilege level;
- the descriptor privilege level and the segment class of the fetched descriptor;
- for gate calls, the privilege level of the target code;
- the I/O privilege level.

The result is registered and appears one clock after the request. It reports exactly one of two outcomes: the request is allowed, or a general protection fault is raised together with an error code. An allowed gate call also reports the privilege level the caller will run at. It raises a stack-switch flag when the call moves inward to a more privileged ring. Fetching the descriptor and performing the stack switch are left to neighbouring logic.

Top module: `seg_priv_check`

## Requirements
- R1: A response appears exactly one clock after `reqValid`, with `rspValid` high for that cycle. In every cycle without a response, `allow`, `gpFault`, `stackSwitch`, `errCode` and `newCpl` are all zero.
- R2: Operation code 0 (load data register) and code 1 (load stack register) with a non-null selector are allowed only when all three hold: the class is data (class code 0), CPL <= DPL, and RPL (selector bits 1:0) <= DPL. Any other case faults.
- R3: Operation code 2 (direct transfer) to nonconforming code (class code 2) is allowed only when DPL equals CPL.
- R4: A direct transfer to conforming code (class code 1) is allowed when CPL >= DPL. After it, `newCpl` equals CPL and `stackSwitch` is low.
- R5: Operation code 3 (gate call) is allowed only when all three hold: the class is a gate (class code 3), CPL <= gate DPL, and target DPL <= CPL. Any other case faults.
- R6: On an allowed gate call, `newCpl` equals the target DPL. `stackSwitch` is high exactly when the target DPL is less than CPL.
- R7: Operation code 4 (I/O) is allowed when CPL <= IOPL. Otherwise it faults with error code 0.
- R8: A null selector has bits 15:2 equal to zero. Loading one with operation code 0 is allowed. Loading one with operation codes 1, 2 or 3 faults with error code 0.
- R9: Every response is either allowed or faulted, never both. A non-I/O fault carries the selector with bits 1:0 cleared. Outside a gate call, `newCpl` equals CPL.
- R10: A class that does not fit the operation faults. Examples are a gate or data class on a direct transfer, or a code class on a data load. Operation codes 5 to 7 also fault, with error code 0.
- R11: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe |
| opKind | input | 3 | Operation code (0 data load, 1 stack load, 2 direct transfer, 3 gate call, 4 I/O) |
| segClass | input | 2 | Descriptor class (0 data, 1 conforming code, 2 nonconforming code, 3 gate) |
| selector | input | 16 | Selector being loaded; bits 1:0 are RPL |
| cpl | input | 2 | Current privilege level |
| descDpl | input | 2 | Descriptor (or gate) privilege level |
| targetDpl | input | 2 | Privilege level of the gate's target code |
| iopl | input | 2 | I/O privilege level |
| rspValid | output | 1 | Response strobe |
| allow | output | 1 | Request permitted |
| gpFault | output | 1 | General protection fault |
| errCode | output | 16 | Fault error code |
| stackSwitch | output | 1 | Inward gate call needs a new stack |
| newCpl | output | 2 | Privilege level after the request |

## Verification
The assertions assume the inputs are stable and known whenever `reqValid` is high. They also assume that a fetched descriptor has already been matched to the selector, so the unit never has to check their consistency. The stimulus draws every field across its full range, including the undefined operation codes. It drives a fresh request on each falling edge, so all request fields are settled before the edge that registers them. Directed cases sit on both sides of each privilege comparison and cover the null selector.

// File: rtl/seg_priv_pkg.sv
package seg_priv_pkg;

  typedef enum logic [2:0] {
    OP_LOAD_DATA  = 3'd0,
    OP_LOAD_STACK = 3'd1,
    OP_JUMP       = 3'd2,
    OP_GATE_CALL  = 3'd3,
    OP_IO         = 3'd4
  } opKind_e;

  typedef enum logic [1:0] {
    CLS_DATA    = 2'd0,
    CLS_CONFORM = 2'd1,
    CLS_NONCONF = 2'd2,
    CLS_GATE    = 2'd3
  } segClass_e;

  // Comparison results produced by the datapath for the control
  typedef struct packed {
    logic nullSel;
    logic cplLeDpl;
    logic rplLeDpl;
    logic cplEqDpl;
    logic cplGeDpl;
    logic tgtLeCpl;
    logic tgtLtCpl;
    logic cplLeIopl;
  } cmpFlags_t;

  // Decision strobes produced by the control for the datapath
  typedef struct packed {
    logic allow;
    logic fault;
    logic selCode;
    logic stackSwitch;
    logic takeTarget;
  } ctrlStrobes_t;

endpackage

// File: rtl/seg_priv_ctrl.sv
module seg_priv_ctrl
  import seg_priv_pkg::*;
(
  input  logic [2:0]   opKind,
  input  logic [1:0]   segClass,
  input  cmpFlags_t    flags,
  output ctrlStrobes_t strobes
);

  opKind_e   op;
  segClass_e cls;
  logic      grant;

  assign op  = opKind_e'(opKind);
  assign cls = segClass_e'(segClass);

  always_comb begin
    grant   = 1'b0;
    strobes = '0;
    strobes.selCode = 1'b1;
    case (op)
      OP_LOAD_DATA: begin
        if (flags.nullSel) grant = 1'b1;
        else grant = (cls == CLS_DATA) && flags.cplLeDpl && flags.rplLeDpl;
      end
      OP_LOAD_STACK: begin
        grant = !flags.nullSel && (cls == CLS_DATA) && flags.cplLeDpl && flags.rplLeDpl;
      end
      OP_JUMP: begin
        if (flags.nullSel)             grant = 1'b0;
        else if (cls == CLS_CONFORM)   grant = flags.cplGeDpl;
        else if (cls == CLS_NONCONF)   grant = flags.cplEqDpl;
        else                           grant = 1'b0;
      end
      OP_GATE_CALL: begin
        grant = !flags.nullSel && (cls == CLS_GATE) && flags.cplLeDpl && flags.tgtLeCpl;
        strobes.takeTarget  = grant;
        strobes.stackSwitch = grant && flags.tgtLtCpl;
      end
      OP_IO: begin
        grant = flags.cplLeIopl;
        strobes.selCode = 1'b0;
      end
      default: begin
        grant = 1'b0;
        strobes.selCode = 1'b0;
      end
    endcase
    strobes.allow = grant;
    strobes.fault = !grant;
  end

endmodule

// File: rtl/seg_priv_dp.sv
module seg_priv_dp
  import seg_priv_pkg::*;
#(
  parameter int SEL_W  = 16,
  parameter int PRIV_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [SEL_W-1:0]   selector,
  input  logic [PRIV_W-1:0]  cpl,
  input  logic [PRIV_W-1:0]  descDpl,
  input  logic [PRIV_W-1:0]  targetDpl,
  input  logic [PRIV_W-1:0]  iopl,
  input  ctrlStrobes_t       strobes,
  output cmpFlags_t          flags,
  output logic               rspValid,
  output logic               allow,
  output logic               gpFault,
  output logic [SEL_W-1:0]   errCode,
  output logic               stackSwitch,
  output logic [PRIV_W-1:0]  newCpl
);

  localparam int IDX_W = SEL_W - PRIV_W;

  logic [PRIV_W-1:0] rpl;
  logic [SEL_W-1:0]  selMasked;
  logic [SEL_W-1:0]  codeNext;
  logic [PRIV_W-1:0] cplNext;

  assign rpl       = selector[PRIV_W-1:0];
  assign selMasked = {selector[SEL_W-1:PRIV_W], {PRIV_W{1'b0}}};

  always_comb begin
    flags.nullSel   = (selector[SEL_W-1:PRIV_W] == {IDX_W{1'b0}});
    flags.cplLeDpl  = (cpl <= descDpl);
    flags.rplLeDpl  = (rpl <= descDpl);
    flags.cplEqDpl  = (cpl == descDpl);
    flags.cplGeDpl  = (cpl >= descDpl);
    flags.tgtLeCpl  = (targetDpl <= cpl);
    flags.tgtLtCpl  = (targetDpl < cpl);
    flags.cplLeIopl = (cpl <= iopl);
  end

  assign codeNext = (strobes.fault && strobes.selCode) ? selMasked : '0;
  assign cplNext  = (strobes.allow && strobes.takeTarget) ? targetDpl : cpl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      allow       <= 1'b0;
      gpFault     <= 1'b0;
      errCode     <= '0;
      stackSwitch <= 1'b0;
      newCpl      <= '0;
    end else if (reqValid) begin
      rspValid    <= 1'b1;
      allow       <= strobes.allow;
      gpFault     <= strobes.fault;
      errCode     <= codeNext;
      stackSwitch <= strobes.allow && strobes.stackSwitch;
      newCpl      <= cplNext;
    end else begin
      rspValid    <= 1'b0;
      allow       <= 1'b0;
      gpFault     <= 1'b0;
      errCode     <= '0;
      stackSwitch <= 1'b0;
      newCpl      <= '0;
    end
  end

endmodule

// File: rtl/seg_priv_check.sv
module seg_priv_check
  import seg_priv_pkg::*;
#(
  parameter int SEL_W  = 16,
  parameter int PRIV_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        opKind,
  input  logic [1:0]        segClass,
  input  logic [SEL_W-1:0]  selector,
  input  logic [PRIV_W-1:0] cpl,
  input  logic [PRIV_W-1:0] descDpl,
  input  logic [PRIV_W-1:0] targetDpl,
  input  logic [PRIV_W-1:0] iopl,
  output logic              rspValid,
  output logic              allow,
  output logic              gpFault,
  output logic [SEL_W-1:0]  errCode,
  output logic              stackSwitch,
  output logic [PRIV_W-1:0] newCpl
);

  cmpFlags_t    flags;
  ctrlStrobes_t strobes;

  seg_priv_ctrl u_ctrl (
    .opKind   (opKind),
    .segClass (segClass),
    .flags    (flags),
    .strobes  (strobes)
  );

  seg_priv_dp #(.SEL_W(SEL_W), .PRIV_W(PRIV_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .selector    (selector),
    .cpl         (cpl),
    .descDpl     (descDpl),
    .targetDpl   (targetDpl),
    .iopl        (iopl),
    .strobes     (strobes),
    .flags       (flags),
    .rspValid    (rspValid),
    .allow       (allow),
    .gpFault     (gpFault),
    .errCode     (errCode),
    .stackSwitch (stackSwitch),
    .newCpl      (newCpl)
  );

endmodule

// File: rtl/seg_priv_check_sva.sv
module seg_priv_check_sva #(
  parameter int SEL_W  = 16,
  parameter int PRIV_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [2:0]        opKind,
  input logic [SEL_W-1:0]  selector,
  input logic [PRIV_W-1:0] cpl,
  input logic [PRIV_W-1:0] iopl,
  input logic              rspValid,
  input logic              allow,
  input logic              gpFault,
  input logic [SEL_W-1:0]  errCode,
  input logic              stackSwitch
);

  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!allow && !gpFault && !stackSwitch && errCode == '0));

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (allow ^ gpFault));

  p_code_aligned_r9: assert property (@(posedge clk) disable iff (!rstN)
    errCode[PRIV_W-1:0] == '0);

  p_switch_allowed_r6: assert property (@(posedge clk) disable iff (!rstN)
    stackSwitch |-> (rspValid && allow));

  p_io_fault_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opKind == 3'd4 && cpl > iopl) |=> (gpFault && errCode == '0));

  p_null_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opKind == 3'd0 && selector[SEL_W-1:PRIV_W] == '0) |=> allow);

endmodule

bind seg_priv_check seg_priv_check_sva #(.SEL_W(SEL_W), .PRIV_W(PRIV_W)) u_sva (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .opKind      (opKind),
  .selector    (selector),
  .cpl         (cpl),
  .iopl        (iopl),
  .rspValid    (rspValid),
  .allow       (allow),
  .gpFault     (gpFault),
  .errCode     (errCode),
  .stackSwitch (stackSwitch)
);

// File: tb/seg_priv_check_tb.sv
`timescale 1ns/1ps
module seg_priv_check_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  opKind = '0;
  logic [1:0]  segClass = '0;
  logic [15:0] selector = '0;
  logic [1:0]  cpl = '0, descDpl = '0, targetDpl = '0, iopl = '0;
  logic        rspValid, allow, gpFault, stackSwitch;
  logic [15:0] errCode;
  logic [1:0]  newCpl;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  seg_priv_check u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opKind(opKind),
    .segClass(segClass), .selector(selector), .cpl(cpl), .descDpl(descDpl),
    .targetDpl(targetDpl), .iopl(iopl), .rspValid(rspValid), .allow(allow),
    .gpFault(gpFault), .errCode(errCode), .stackSwitch(stackSwitch), .newCpl(newCpl)
  );

  // packed expectation: {rspValid, allow, fault, code, switch, newCpl}
  typedef struct packed {
    logic        v;
    logic        ok;
    logic        gp;
    logic [15:0] code;
    logic        sw;
    logic [1:0]  nc;
  } resp_t;

  function automatic resp_t model(input logic [2:0] op, input logic [1:0] cls,
                                  input logic [15:0] sel, input int c, input int d,
                                  input int t, input int io);
    resp_t r;
    bit    isNull;
    bit    ok;
    int    rpl;
    isNull = (sel[15:2] == 14'd0);
    rpl    = int'(sel[1:0]);
    ok     = 0;
    r      = '0;
    r.v    = 1'b1;
    r.nc   = 2'(c);
    case (op)
      3'd0: ok = isNull || (cls == 2'd0 && c <= d && rpl <= d);
      3'd1: ok = !isNull && cls == 2'd0 && c <= d && rpl <= d;
      3'd2: ok = !isNull && ((cls == 2'd1 && c >= d) || (cls == 2'd2 && c == d));
      3'd3: ok = !isNull && cls == 2'd3 && c <= d && t <= c;
      3'd4: ok = (c <= io);
      default: ok = 0;
    endcase
    r.ok = ok;
    r.gp = !ok;
    if (!ok && op <= 3'd3) r.code = {sel[15:2], 2'b00};
    if (ok && op == 3'd3) begin
      r.nc = 2'(t);
      r.sw = (t < c);
    end
    return r;
  endfunction

  function automatic string tagFor(input logic [2:0] op, input logic [1:0] cls,
                                   input logic [15:0] sel);
    if (op == 3'd4) return "R7";
    if (op > 3'd4) return "R10";
    if (sel[15:2] == 14'd0) return "R8";
    if (op == 3'd3) return "R5/R6";
    if (op == 3'd2) return (cls == 2'd1) ? "R4" : ((cls == 2'd2) ? "R3" : "R10");
    return "R2";
  endfunction

  task automatic compare(input resp_t exp, input string tag);
    resp_t act;
    act = {rspValid, allow, gpFault, errCode, stackSwitch, newCpl};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual v=%0b ok=%0b gp=%0b code=%h sw=%0b nc=%0d expected v=%0b ok=%0b gp=%0b code=%h sw=%0b nc=%0d",
               tag, act.v, act.ok, act.gp, act.code, act.sw, act.nc,
               exp.v, exp.ok, exp.gp, exp.code, exp.sw, exp.nc);
    end
  endtask

  // Drive at a falling edge, check at the next falling edge (one register stage)
  task automatic issue(input logic [2:0] op, input logic [1:0] cls, input logic [15:0] sel,
                       input int c, input int d, input int t, input int io);
    resp_t exp;
    exp = model(op, cls, sel, c, d, t, io);
    reqValid  = 1'b1;
    opKind    = op;
    segClass  = cls;
    selector  = sel;
    cpl       = 2'(c);
    descDpl   = 2'(d);
    targetDpl = 2'(t);
    iopl      = 2'(io);
    @(negedge clk);
    compare(exp, tagFor(op, cls, sel));
  endtask

  task automatic idleCheck();
    reqValid = 1'b0;
    @(negedge clk);
    compare('0, "R1");
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    compare('0, "R11");
    rstN = 1'b1;
    @(negedge clk);
    compare('0, "R1");

    // R2 data/stack loads
    issue(3'd0, 2'd0, 16'h0043, 3, 2, 0, 0);   // CPL above DPL: fault, code 0x0040
    issue(3'd0, 2'd0, 16'h0043, 0, 2, 0, 0);   // RPL 3 above DPL 2: fault
    issue(3'd0, 2'd0, 16'h0042, 2, 2, 0, 0);   // equal levels: allow
    issue(3'd1, 2'd0, 16'h0011, 1, 3, 0, 0);   // stack load allowed
    issue(3'd0, 2'd2, 16'h0020, 0, 3, 0, 0);   // R10 code class on data load
    // R8 null selectors
    issue(3'd0, 2'd2, 16'h0003, 3, 0, 0, 0);
    issue(3'd1, 2'd0, 16'h0002, 0, 3, 0, 0);
    issue(3'd2, 2'd2, 16'h0000, 0, 0, 0, 0);
    issue(3'd3, 2'd3, 16'h0001, 0, 3, 0, 0);
    // R3 nonconforming
    issue(3'd2, 2'd2, 16'h0108, 1, 1, 0, 0);
    issue(3'd2, 2'd2, 16'h0108, 1, 0, 0, 0);
    // R4 conforming
    issue(3'd2, 2'd1, 16'h0208, 3, 0, 0, 0);
    issue(3'd2, 2'd1, 16'h0208, 0, 3, 0, 0);
    issue(3'd2, 2'd3, 16'h0208, 0, 0, 0, 0);   // R10 gate class on direct transfer
    // R5/R6 gate calls
    issue(3'd3, 2'd3, 16'h0307, 3, 3, 0, 0);   // inward: switch, newCpl 0
    issue(3'd3, 2'd3, 16'h0307, 2, 3, 2, 0);   // same ring: no switch
    issue(3'd3, 2'd3, 16'h0307, 3, 2, 0, 0);   // gate DPL too privileged
    issue(3'd3, 2'd3, 16'h0307, 1, 3, 3, 0);   // outward target: fault
    issue(3'd3, 2'd2, 16'h0307, 0, 3, 0, 0);   // not a gate
    // R7 I/O
    issue(3'd4, 2'd0, 16'hFFFF, 3, 0, 0, 3);
    issue(3'd4, 2'd0, 16'hFFFF, 3, 0, 0, 0);
    // R10 undefined operations
    issue(3'd5, 2'd0, 16'h1234, 0, 3, 0, 3);
    issue(3'd7, 2'd3, 16'h5678, 0, 3, 0, 3);
    idleCheck();

    for (int i = 0; i < 3000; i++) begin
      issue(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
            ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, 3)) : 16'($urandom),
            $urandom_range(0, 3), $urandom_range(0, 3),
            $urandom_range(0, 3), $urandom_range(0, 3));
      if ($urandom_range(0, 15) == 0) idleCheck();
    end
    idleCheck();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule